// File: doc/BRIEF.md
# Register-File Stack with Zero-Address Arithmetic

This block is a last-in-first-out store made of a bank of general registers and addressed by a wrapping stack pointer. A requester presents one operation per cycle with a valid strobe. A push places the input word on top of the stack. A pop returns the top word on the data output. A calculate request combines the two topmost words and leaves a single result in their place. No operand field is needed, so the block can execute zero-address arithmetic directly.

Two status flags report a completely filled stack and a drained stack. Any request that cannot be carried out is dropped without touching the registers, the pointer or the flags. A one-cycle refusal pulse signals the drop. Each outcome appears on the outputs one clock after the edge that samples the request.

Top module: `reg_stack_alu`

## Requirements
- R1: After reset the pointer output is 0, `is_empty` is 1, `is_full` is 0, and neither `pop_valid` nor `refused` is asserted.
- R2: An accepted push first adds one to the pointer and then writes `push_data` into the register the new pointer selects. The first push after reset lands in register 1 and leaves the pointer at 1. Every accepted push clears `is_empty`.
- R3: Pointer arithmetic is modulo 64. The push that holds the 64th word moves the pointer from 63 to 0, stores its word in register 0, sets `is_full` and clears `is_empty`.
- R4: A push (`op_kind` 00) issued while `is_full` is 1 is dropped. `refused` pulses and the pointer, the flags and the stored words stay unchanged.
- R5: An accepted pop (`op_kind` 01) places the register at the current pointer on `pop_data`, with `pop_valid` high for one cycle, and then subtracts one from the pointer. Every accepted pop clears `is_full`.
- R6: A pop that leaves the pointer at 0 sets `is_empty` and clears `is_full`.
- R7: A pop issued while `is_empty` is 1 is dropped. `refused` pulses, `pop_valid` stays low and the state is unchanged.
- R8: An accepted calculate request (`op_kind` 10) takes the top word T and the word below it D. It writes f(D,T) into D's register, subtracts one from the pointer and clears `is_full`. The function is chosen by `calc_op`: 00 is D+T, 01 is D−T, 10 is D×T and 11 is D AND T. This also holds when the stack is full, where T sits in register 0 and D in register 63.
- R9: A calculate request issued while fewer than two words are stored is dropped. `refused` pulses and the state is unchanged.
- R10: `is_full` and `is_empty` are never 1 at the same time.
- R11: The reserved `op_kind` value 11 is always dropped with a `refused` pulse, and the state is unchanged.
- R12: Arithmetic results are truncated to the data width. A product keeps only its low half, and sums and differences wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A request is presented this cycle |
| op_kind | input | 2 | 00 push, 01 pop, 10 calculate, 11 reserved |
| calc_op | input | 2 | Calculate function: 00 add, 01 subtract, 10 multiply low half, 11 AND |
| push_data | input | DATA_W | Word to be pushed |
| pop_data | output | DATA_W | Word returned by the latest pop |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` is new |
| top_ptr | output | PTR_W | Current stack pointer |
| is_full | output | 1 | All 64 registers are occupied |
| is_empty | output | 1 | No register is occupied |
| refused | output | 1 | One-cycle pulse: the previous request was dropped |

## Verification
The hardest situation to reach is the full stack. There the pointer has wrapped to 0, the top word lives in register 0 and its neighbour lives in register 63. A calculate request or a pop must step back across the wrap without setting `is_empty`. The stimulus gets there by issuing 64 pushes in a row. It then tries a 65th push, runs a calculate on the wrapped pair, refills the stack and drains it to empty. After that it runs a long random mix biased toward pushes, so the stack revisits the full boundary many times. A queue-based model predicts every output on every cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        REQ_PUSH = 2'b00,
        REQ_POP  = 2'b01,
        REQ_CALC = 2'b10,
        REQ_RSVD = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        CALC_ADD = 2'b00,
        CALC_SUB = 2'b01,
        CALC_MUL = 2'b10,
        CALC_AND = 2'b11
    } calc_op_e;

    // Decision for the current cycle: exactly one field is set when a request is present
    typedef struct packed {
        logic push;
        logic pop;
        logic calc;
        logic refuse;
    } dispatch_t;

    // Register count for a given pointer width
    function automatic int unsigned slot_count(input int unsigned ptr_w);
        return 32'd1 << ptr_w;
    endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    output dispatch_t        act,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_up,
    output logic [PTR_W-1:0] ptr_dn,
    output logic             full,
    output logic             empty,
    output logic             refuse_pulse
);

    localparam logic [PTR_W-1:0] PTR_ZERO = '0;
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic             full_q;
    logic             empty_q;
    logic             refuse_q;
    logic             two_plus;
    req_kind_e        kind;

    assign kind   = req_kind_e'(req_kind);
    assign ptr_up = ptr_q + PTR_ONE;
    assign ptr_dn = ptr_q - PTR_ONE;

    // Between the flag states the pointer equals the word count
    assign two_plus = full_q | (!empty_q && (ptr_q != PTR_ONE));

    always_comb begin
        act = '0;
        if (req_valid) begin
            unique case (kind)
                REQ_PUSH: if (!full_q)  act.push = 1'b1; else act.refuse = 1'b1;
                REQ_POP:  if (!empty_q) act.pop  = 1'b1; else act.refuse = 1'b1;
                REQ_CALC: if (two_plus) act.calc = 1'b1; else act.refuse = 1'b1;
                default:  act.refuse = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= PTR_ZERO;
            full_q   <= 1'b0;
            empty_q  <= 1'b1;
            refuse_q <= 1'b0;
        end else begin
            refuse_q <= act.refuse;
            if (act.push) begin
                ptr_q   <= ptr_up;
                full_q  <= (ptr_up == PTR_ZERO);
                empty_q <= 1'b0;
            end else if (act.pop) begin
                ptr_q   <= ptr_dn;
                empty_q <= (ptr_dn == PTR_ZERO);
                full_q  <= 1'b0;
            end else if (act.calc) begin
                ptr_q   <= ptr_dn;
                full_q  <= 1'b0;
            end
        end
    end

    assign ptr          = ptr_q;
    assign full         = full_q;
    assign empty        = empty_q;
    assign refuse_pulse = refuse_q;

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr_top,
    input  logic [PTR_W-1:0]  raddr_next,
    output logic [DATA_W-1:0] rdata_top,
    output logic [DATA_W-1:0] rdata_next
);

    localparam int SLOTS = stk_pkg::slot_count(PTR_W);

    logic [DATA_W-1:0] bank [SLOTS];

    always_ff @(posedge clk) begin
        if (we) bank[waddr] <= wdata;
    end

    assign rdata_top  = bank[raddr_top];
    assign rdata_next = bank[raddr_next];

endmodule

// File: rtl/stk_calc.sv
module stk_calc
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] deeper,
    input  logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] result
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] product;

    assign product = PROD_W'(deeper) * PROD_W'(top);

    always_comb begin
        unique case (calc_op_e'(op))
            CALC_ADD: result = deeper + top;
            CALC_SUB: result = deeper - top;
            CALC_MUL: result = product[DATA_W-1:0];
            default:  result = deeper & top;
        endcase
    end

endmodule

// File: rtl/reg_stack_alu.sv
module reg_stack_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        calc_op,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              is_full,
    output logic              is_empty,
    output logic              refused
);

    dispatch_t         act;
    logic [PTR_W-1:0]  ptr, ptr_up, ptr_dn;
    logic [DATA_W-1:0] word_top, word_next, calc_res;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] pop_data_q;
    logic              pop_valid_q;

    stk_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (op_valid),
        .req_kind     (op_kind),
        .act          (act),
        .ptr          (ptr),
        .ptr_up       (ptr_up),
        .ptr_dn       (ptr_dn),
        .full         (is_full),
        .empty        (is_empty),
        .refuse_pulse (refused)
    );

    stk_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .we         (wr_en),
        .waddr      (wr_addr),
        .wdata      (wr_data),
        .raddr_top  (ptr),
        .raddr_next (ptr_dn),
        .rdata_top  (word_top),
        .rdata_next (word_next)
    );

    stk_calc #(.DATA_W(DATA_W)) u_calc (
        .op     (calc_op),
        .deeper (word_next),
        .top    (word_top),
        .result (calc_res)
    );

    // Push writes above the top; calculate overwrites the deeper operand
    assign wr_en   = act.push | act.calc;
    assign wr_addr = act.push ? ptr_up : ptr_dn;
    assign wr_data = act.push ? push_data : calc_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data_q  <= '0;
            pop_valid_q <= 1'b0;
        end else begin
            pop_valid_q <= act.pop;
            if (act.pop) pop_data_q <= word_top;
        end
    end

    assign pop_data  = pop_data_q;
    assign pop_valid = pop_valid_q;
    assign top_ptr   = ptr;

endmodule

// File: rtl/stk_check.sv
module stk_check #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [1:0]       op_kind,
    input logic [PTR_W-1:0] top_ptr,
    input logic             is_full,
    input logic             is_empty,
    input logic             refused,
    input logic             pop_valid
);

    localparam logic [PTR_W-1:0] PTR_MAX = '1;
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic push_req, pop_req, calc_req, rsvd_req;
    assign push_req = op_valid && (op_kind == 2'b00);
    assign pop_req  = op_valid && (op_kind == 2'b01);
    assign calc_req = op_valid && (op_kind == 2'b10);
    assign rsvd_req = op_valid && (op_kind == 2'b11);

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(is_full && is_empty));

    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        push_req && !is_full |=> top_ptr == PTR_W'($past(top_ptr) + PTR_ONE) && !is_empty);

    p_wrap_full_r3: assert property (@(posedge clk) disable iff (rst)
        push_req && !is_full && top_ptr == PTR_MAX |=> is_full && !is_empty && top_ptr == '0);

    p_push_full_refused_r4: assert property (@(posedge clk) disable iff (rst)
        push_req && is_full |=> refused && is_full && top_ptr == $past(top_ptr));

    p_pop_step_r5: assert property (@(posedge clk) disable iff (rst)
        pop_req && !is_empty |=> pop_valid && !is_full && top_ptr == PTR_W'($past(top_ptr) - PTR_ONE));

    p_drain_empty_r6: assert property (@(posedge clk) disable iff (rst)
        pop_req && !is_full && top_ptr == PTR_ONE |=> is_empty && !is_full);

    p_pop_empty_refused_r7: assert property (@(posedge clk) disable iff (rst)
        pop_req && is_empty |=> refused && !pop_valid && is_empty && top_ptr == $past(top_ptr));

    p_calc_short_refused_r9: assert property (@(posedge clk) disable iff (rst)
        calc_req && !is_full && top_ptr <= PTR_ONE |=> refused && top_ptr == $past(top_ptr));

    p_rsvd_refused_r11: assert property (@(posedge clk) disable iff (rst)
        rsvd_req |=> refused && top_ptr == $past(top_ptr) && is_full == $past(is_full));

endmodule

bind reg_stack_alu stk_check #(.PTR_W(PTR_W)) u_stk_check (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .top_ptr   (top_ptr),
    .is_full   (is_full),
    .is_empty  (is_empty),
    .refused   (refused),
    .pop_valid (pop_valid)
);

// File: tb/test_reg_stack_alu.sv
`timescale 1ns/1ps
module test_reg_stack_alu;

    localparam int DW = 16;
    localparam int PW = 6;
    localparam int CAP = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [1:0]    calc_op = 2'b00;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic [PW-1:0] top_ptr;
    logic          is_full, is_empty, refused;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [DW-1:0] model_q[$];

    always #2 clk = ~clk;

    reg_stack_alu #(.DATA_W(DW), .PTR_W(PW)) i_reg_stack_alu (
        .clk, .rst, .op_valid, .op_kind, .calc_op, .push_data,
        .pop_data, .pop_valid, .top_ptr, .is_full, .is_empty, .refused
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_calc(input logic [1:0] op,
                                               input logic [DW-1:0] d,
                                               input logic [DW-1:0] t);
        logic [2*DW-1:0] p;
        p = {{DW{1'b0}}, d} * {{DW{1'b0}}, t};
        case (op)
            2'b00:   return d + t;
            2'b01:   return d - t;
            2'b10:   return p[DW-1:0];
            default: return d & t;
        endcase
    endfunction

    // Compare state outputs with the model (called at a falling edge)
    task automatic check_state(input string tag);
        chk({tag, " R2 ptr"}, top_ptr, model_q.size() % CAP);
        chk({tag, " R3 full"}, is_full, model_q.size() == CAP);
        chk({tag, " R6 empty"}, is_empty, model_q.size() == 0);
        chk("R10 flags exclusive", is_full & is_empty, 0);
    endtask

    // Issue one request at a falling edge; verify one cycle later
    task automatic issue(input logic [1:0] k, input logic [1:0] op, input logic [DW-1:0] d);
        bit            exp_ref = 0;
        bit            exp_pop = 0;
        logic [DW-1:0] exp_data = '0;
        int            n = model_q.size();
        string         tag;
        case (k)
            2'b00: begin tag = "R4 push";
                if (n == CAP) exp_ref = 1; else model_q.push_back(d); end
            2'b01: begin tag = "R7 pop";
                if (n == 0) exp_ref = 1;
                else begin exp_pop = 1; exp_data = model_q.pop_back(); end end
            2'b10: begin tag = "R9 calc";
                if (n < 2) exp_ref = 1;
                else begin
                    logic [DW-1:0] t, dd;
                    t  = model_q.pop_back();
                    dd = model_q.pop_back();
                    model_q.push_back(ref_calc(op, dd, t));
                end end
            default: begin tag = "R11 reserved"; exp_ref = 1; end
        endcase
        op_valid = 1'b1; op_kind = k; calc_op = op; push_data = d;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " refused"}, refused, exp_ref);
        chk("R5 pop_valid", pop_valid, exp_pop);
        if (exp_pop) chk("R5 R8 R12 pop_data", pop_data, exp_data);
        check_state(tag);
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
        chk("R1 idle refused", refused, 0);
        chk("R1 idle pop_valid", pop_valid, 0);
        check_state("idle");
    endtask

    initial begin : watchdog
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ptr", top_ptr, 0);
        chk("R1 empty", is_empty, 1);
        chk("R1 full", is_full, 0);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 refused", refused, 0);
        idle_cycle();

        issue(2'b01, 2'b00, '0);          // R7 pop empty
        issue(2'b10, 2'b00, '0);          // R9 calc with none
        issue(2'b00, 2'b00, 16'h1234);    // R2 first push -> ptr 1
        issue(2'b10, 2'b00, '0);          // R9 calc with one
        issue(2'b11, 2'b00, '0);          // R11 reserved
        issue(2'b01, 2'b00, '0);          // R5/R6 pop back to empty

        // R8 each function, R12 truncation
        for (int op = 0; op < 4; op++) begin
            issue(2'b00, 2'b00, 16'hF00D);
            issue(2'b00, 2'b00, 16'h8123);
            issue(2'b10, op[1:0], '0);
            issue(2'b01, 2'b00, '0);
        end
        issue(2'b00, 2'b00, 16'hFFFF);
        issue(2'b00, 2'b00, 16'hFFFF);
        issue(2'b10, 2'b10, '0);          // R12 product low half = 0001
        issue(2'b00, 2'b00, 16'h0005);
        issue(2'b10, 2'b01, '0);          // R12 1 - 5 wraps
        issue(2'b01, 2'b00, '0);

        // R3 fill to 64, R4 overflow attempt, R8 calc across wrap
        for (int i = 0; i < CAP; i++) issue(2'b00, 2'b00, DW'(i * 37 + 11));
        issue(2'b00, 2'b00, 16'hDEAD);    // R4
        issue(2'b11, 2'b01, '0);          // R11 while full
        issue(2'b10, 2'b01, '0);          // R8 reg63 - reg0
        issue(2'b00, 2'b00, 16'h0777);
        for (int i = 0; i < CAP + 2; i++) issue(2'b01, 2'b00, '0);  // R6 drain, R7 extra
        idle_cycle();

        // Random mix biased to pushes
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [1:0] k = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
            issue(k, 2'($urandom), 16'($urandom));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule